// File: doc/BRIEF.md
# Automatic RTS/CTS Hardware Flow Controller

This block handles hardware handshaking for a single serial channel. On the receive side it watches the fill count of the receive FIFO. It compares that count against three programmed thresholds: a trigger level, an upper level and a lower level. From these it drives the active-low request-to-send output and a receive-trigger interrupt flag. The upper and lower levels form a hysteresis band. Once the request has been dropped because the FIFO is filling up, it is not granted again until the FIFO has drained well below that point.

On the transmit side the block brings the asynchronous active-low clear-to-send input into the clock domain through a flop synchronizer. It then produces a permission signal for the transmitter. A character that is already being shifted out keeps its permission until it is finished, so a halt only takes effect between characters. Automatic request control and automatic clear control each have their own enable. With automatic request control off, the request pin simply follows a software register bit.

Top module: `rts_cts_flow_ctrl`

## Requirements
- R1: While reset is held and on the first cycle after it, rxTrigIrq is 0, the flow-off state is clear (rtsN equals the inverse of swRtsAssert), and the synchronized clear-to-send reads as deasserted (high).
- R2: rxTrigIrq is 1 in the cycle after an edge at which autoRtsEn is 1 and fillCount >= trigLevel. It is 0 in the cycle after an edge at which fillCount < trigLevel or autoRtsEn is 0.
- R3: With autoRtsEn = 1 and swRtsAssert = 1, rtsN goes high (deasserted) in the cycle after an edge at which fillCount >= upperLevel.
- R4: Once rtsN has been driven high by R3, it stays high while fillCount >= lowerLevel. It returns low in the cycle after an edge at which fillCount < lowerLevel and fillCount < upperLevel.
- R5: When upperLevel <= lowerLevel, reaching the upper level takes priority. rtsN stays high for any fill count at or above upperLevel, so it never toggles while the count is held constant.
- R6: With autoRtsEn = 0, rtsN equals the inverse of swRtsAssert in the same cycle, whatever the fill count.
- R7: Automatic control only acts while swRtsAssert = 1. With swRtsAssert = 0, rtsN is high, and the flow-off state is cleared at the next edge.
- R8: With autoCtsEn = 1 and txCharActive = 0, txAllow equals the inverse of ctsN as sampled SYNC_STAGES clock edges earlier.
- R9: While txCharActive = 1, txAllow is 1, so a character in flight finishes before the halt.
- R10: With autoCtsEn = 0, txAllow is 1 regardless of ctsN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| autoRtsEn | input | 1 | Enables automatic request-to-send control |
| autoCtsEn | input | 1 | Enables automatic clear-to-send gating |
| swRtsAssert | input | 1 | Software request bit, 1 = assert (drive rtsN low) |
| fillCount | input | FILL_W | Current receive FIFO fill count |
| trigLevel | input | FILL_W | Receive trigger level for the interrupt |
| upperLevel | input | FILL_W | Fill count at which the request is dropped |
| lowerLevel | input | FILL_W | Fill count below which the request is restored |
| ctsN | input | 1 | Asynchronous active-low clear-to-send |
| txCharActive | input | 1 | Transmitter is shifting a character |
| rtsN | output | 1 | Active-low request-to-send |
| rxTrigIrq | output | 1 | Receive trigger interrupt flag |
| txAllow | output | 1 | Permission for the transmitter to send |

## Verification
The bench builds the block with FILL_W = 7 and SYNC_STAGES = 2. A 7-bit count reaches the full range of a 64-entry FIFO and lets the ramps run past the upper level. Two synchronizer stages make the clear-to-send latency a short, exact number of cycles that a per-edge queue can follow. Threshold sets with a normal band (upper above lower) and an inverted band (upper below lower) exercise both orderings of the hysteresis comparison.

// File: rtl/flow_pkg.sv
package flow_pkg;
  // Comparison results handed from datapath to control each cycle
  typedef struct packed {
    logic atTrig;      // fill >= trigger level
    logic atUpper;     // fill >= upper level
    logic belowLower;  // fill < lower level
    logic ctsOff;      // synchronized clear-to-send is deasserted
  } flowFlags_t;
endpackage

// File: rtl/flow_datapath.sv
module flow_datapath
  import flow_pkg::*;
#(
  parameter int FILL_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FILL_W-1:0] fillCount,
  input  logic [FILL_W-1:0] trigLevel,
  input  logic [FILL_W-1:0] upperLevel,
  input  logic [FILL_W-1:0] lowerLevel,
  input  logic              ctsN,
  output flowFlags_t        flags
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] ctsPipe;

  // Synchronizer chain, reset to the deasserted level
  always_ff @(posedge clk) begin
    if (!rstN) ctsPipe[0] <= 1'b1;
    else       ctsPipe[0] <= ctsN;
  end

  for (genvar s = 1; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk) begin
      if (!rstN) ctsPipe[s] <= 1'b1;
      else       ctsPipe[s] <= ctsPipe[s-1];
    end
  end

  always_comb begin
    flags.atTrig     = (fillCount >= trigLevel);
    flags.atUpper    = (fillCount >= upperLevel);
    flags.belowLower = (fillCount < lowerLevel);
    flags.ctsOff     = ctsPipe[LAST];
  end
endmodule

// File: rtl/flow_control.sv
module flow_control
  import flow_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       autoRtsEn,
  input  logic       autoCtsEn,
  input  logic       swRtsAssert,
  input  logic       txCharActive,
  input  flowFlags_t flags,
  output logic       rtsN,
  output logic       rxTrigIrq,
  output logic       txAllow
);
  logic flowOff;
  logic flowOffNext;

  // Hysteresis: upper level wins over lower, so an inverted band cannot oscillate
  always_comb begin
    flowOffNext = flowOff;
    if (!autoRtsEn || !swRtsAssert) flowOffNext = 1'b0;
    else if (flags.atUpper)         flowOffNext = 1'b1;
    else if (flags.belowLower)      flowOffNext = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flowOff   <= 1'b0;
      rxTrigIrq <= 1'b0;
    end else begin
      flowOff   <= flowOffNext;
      rxTrigIrq <= autoRtsEn & flags.atTrig;
    end
  end

  assign rtsN    = ~(swRtsAssert & ~(autoRtsEn & flowOff));
  assign txAllow = ~autoCtsEn | ~flags.ctsOff | txCharActive;

  // R2: interrupt is never raised after a cycle with automatic control off
  assert_irq_needs_enable_R2: assert property (@(posedge clk) disable iff (!rstN)
    !autoRtsEn |=> !rxTrigIrq);

  // R3: reaching the upper level drops the request on the next cycle
  assert_rts_drops_at_upper_R3: assert property (@(posedge clk) disable iff (!rstN)
    (autoRtsEn && swRtsAssert && flags.atUpper) |=> (rtsN || !autoRtsEn || !swRtsAssert));

  // R4/R5: no release while still at or above the lower level
  assert_no_early_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    (flowOff && !flags.belowLower && autoRtsEn && swRtsAssert) |=> (flowOff || !autoRtsEn || !swRtsAssert));

  // R7: software deassert clears the flow-off state
  assert_sw_clears_state_R7: assert property (@(posedge clk) disable iff (!rstN)
    !swRtsAssert |=> !flowOff);
endmodule

// File: rtl/rts_cts_flow_ctrl.sv
module rts_cts_flow_ctrl
  import flow_pkg::*;
#(
  parameter int FILL_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              autoRtsEn,
  input  logic              autoCtsEn,
  input  logic              swRtsAssert,
  input  logic [FILL_W-1:0] fillCount,
  input  logic [FILL_W-1:0] trigLevel,
  input  logic [FILL_W-1:0] upperLevel,
  input  logic [FILL_W-1:0] lowerLevel,
  input  logic              ctsN,
  input  logic              txCharActive,
  output logic              rtsN,
  output logic              rxTrigIrq,
  output logic              txAllow
);
  flowFlags_t flags;

  flow_datapath #(.FILL_W(FILL_W), .SYNC_STAGES(SYNC_STAGES)) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .fillCount  (fillCount),
    .trigLevel  (trigLevel),
    .upperLevel (upperLevel),
    .lowerLevel (lowerLevel),
    .ctsN       (ctsN),
    .flags      (flags)
  );

  flow_control u_control (
    .clk          (clk),
    .rstN         (rstN),
    .autoRtsEn    (autoRtsEn),
    .autoCtsEn    (autoCtsEn),
    .swRtsAssert  (swRtsAssert),
    .txCharActive (txCharActive),
    .flags        (flags),
    .rtsN         (rtsN),
    .rxTrigIrq    (rxTrigIrq),
    .txAllow      (txAllow)
  );

  // R9: a character in flight is never cut off
  assert_char_finishes_R9: assert property (@(posedge clk) disable iff (!rstN)
    txCharActive |-> txAllow);

  // R10: gating disabled means free transmission
  assert_free_when_disabled_R10: assert property (@(posedge clk) disable iff (!rstN)
    !autoCtsEn |-> txAllow);

  // R6: manual mode follows the software bit
  assert_manual_rts_R6: assert property (@(posedge clk) disable iff (!rstN)
    !autoRtsEn |-> (rtsN == !swRtsAssert));
endmodule

// File: tb/rts_cts_flow_ctrl_bench.sv
module rts_cts_flow_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int FILL_W     = 7;
  localparam int STAGES     = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic autoRtsEn = 1'b0, autoCtsEn = 1'b0, swRtsAssert = 1'b0;
  logic [FILL_W-1:0] fillCount = '0, trigLevel = '0, upperLevel = '0, lowerLevel = '0;
  logic ctsN = 1'b1, txCharActive = 1'b0;
  logic rtsN, rxTrigIrq, txAllow;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string phase = "R1 reset";

  always #(CLK_PERIOD/2) clk = ~clk;

  rts_cts_flow_ctrl #(.FILL_W(FILL_W), .SYNC_STAGES(STAGES)) u_rts_cts_flow_ctrl (
    .clk(clk), .rstN(rstN), .autoRtsEn(autoRtsEn), .autoCtsEn(autoCtsEn),
    .swRtsAssert(swRtsAssert), .fillCount(fillCount), .trigLevel(trigLevel),
    .upperLevel(upperLevel), .lowerLevel(lowerLevel), .ctsN(ctsN),
    .txCharActive(txCharActive), .rtsN(rtsN), .rxTrigIrq(rxTrigIrq), .txAllow(txAllow)
  );

  // Behavioural reference model, updated at every rising edge
  bit mOff, mIrq;
  bit ctsQ[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mOff = 0;
      mIrq = 0;
      ctsQ = {};
      for (int i = 0; i < STAGES; i++) ctsQ.push_back(1'b1);
    end else begin
      mIrq = autoRtsEn && (int'(fillCount) >= int'(trigLevel));
      if (!autoRtsEn || !swRtsAssert) mOff = 0;
      else if (int'(fillCount) >= int'(upperLevel)) mOff = 1;
      else if (int'(fillCount) < int'(lowerLevel)) mOff = 0;
      void'(ctsQ.pop_front());
      ctsQ.push_back(ctsN);
    end
  end

  task automatic checkOne(string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b", phase, what, act, exp);
    end
  endtask

  // Advance one cycle and compare all outputs at the falling edge
  task automatic step();
    bit expRts, expAllow;
    @(posedge clk);
    @(negedge clk);
    expRts   = !(swRtsAssert && !(autoRtsEn && mOff));
    expAllow = !autoCtsEn || !ctsQ[0] || txCharActive;
    checkOne("rtsN", rtsN, expRts);
    checkOne("rxTrigIrq", rxTrigIrq, mIrq);
    checkOne("txAllow", txAllow, expAllow);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    // R1: reset state
    swRtsAssert = 1;
    repeat (3) step();
    @(negedge clk);
    rstN = 1;
    step();
    checkOne("R1 irq after reset", rxTrigIrq, 1'b0);
    checkOne("R1 rts after reset", rtsN, 1'b0);

    // R2 R3: normal band, ramp up past upper level
    phase = "R2 R3 ramp up";
    trigLevel = 16; upperLevel = 24; lowerLevel = 8;
    autoRtsEn = 1;
    for (int f = 0; f <= 30; f++) begin fillCount = f[FILL_W-1:0]; step(); end
    checkOne("R3 rts high at top", rtsN, 1'b1);
    checkOne("R2 irq high at top", rxTrigIrq, 1'b1);

    // R4: ramp down, release only below lower
    phase = "R4 ramp down";
    for (int f = 30; f >= 0; f--) begin
      fillCount = f[FILL_W-1:0]; step();
      if (f == 8) checkOne("R4 still high at lower", rtsN, 1'b1);
    end
    checkOne("R4 released at bottom", rtsN, 1'b0);

    // R5: inverted band, hold constant values, then ramp
    phase = "R5 inverted band";
    upperLevel = 8; lowerLevel = 20;
    fillCount = 12;
    repeat (6) step();
    checkOne("R5 stays high in band", rtsN, 1'b1);
    for (int f = 25; f >= 0; f--) begin fillCount = f[FILL_W-1:0]; step(); end
    checkOne("R5 released low", rtsN, 1'b0);

    // R6: manual mode
    phase = "R6 manual";
    autoRtsEn = 0; fillCount = 40;
    for (int k = 0; k < 8; k++) begin swRtsAssert = k[0]; step(); end

    // R7: software deassert overrides and clears state
    phase = "R7 software gate";
    autoRtsEn = 1; swRtsAssert = 1; upperLevel = 24; lowerLevel = 8;
    fillCount = 30; repeat (3) step();
    swRtsAssert = 0; repeat (2) step();
    checkOne("R7 rts high with sw off", rtsN, 1'b1);
    fillCount = 12; swRtsAssert = 1; repeat (2) step();
    checkOne("R7 state cleared", rtsN, 1'b0);

    // R8: clear-to-send gating with latency
    phase = "R8 cts gating";
    autoCtsEn = 1;
    for (int k = 0; k < 20; k++) begin ctsN = (k % 5) < 2; step(); end
    ctsN = 1; repeat (STAGES) step();
    checkOne("R8 halted", txAllow, 1'b0);

    // R9: character in flight
    phase = "R9 char in flight";
    txCharActive = 1; repeat (3) step();
    txCharActive = 0; repeat (2) step();

    // R10: gating disabled
    phase = "R10 gating off";
    autoCtsEn = 0;
    for (int k = 0; k < 6; k++) begin ctsN = k[0]; step(); end
    checkOne("R10 allow", txAllow, 1'b1);

    finish();
  end
endmodule